// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block is a clocked controller that sits between a single-word host request port and an external asynchronous static RAM of 512K words by 8 bits. A host access is started by a request strobe with a write flag, an address and write data. The controller then produces a timed sequence on the memory's active-low chip select, write enable and output enable lines. It also controls a split data bus made of an output value, a driver enable and an input value. A one-cycle ready pulse closes every access, and it is the only handshake. A read also leaves the fetched byte on the read-data output.

Every timing interval is a parameter counted in clock cycles. Each default is the memory's nanosecond limit for the selected speed grade (70 ns or 100 ns), divided by the clock period and rounded up. Writes are controlled by write enable. Output enable stays high for the whole write. The controller's own data driver is on only while write enable is low, so the controller and the memory never drive the bus at the same time. Between accesses chip select is high and the memory is deselected.

Top module: `sram_ctl`

## Requirements
- R1: Out of reset and whenever idle, chip select, write enable and output enable are high (deselected), the data driver enable is low and ready is low.
- R2: A read holds chip select and output enable low with write enable high for exactly RD_CYC cycles. RD_CYC is the largest of the address, chip-select and output-enable access times in cycles. The input byte present in the last of those cycles appears on rdata_o and stays there until the next read.
- R3: After a read, chip select and output enable stay high for TURN_CYC cycles before ready, so that the memory's outputs have floated before the next access can start. TURN_CYC is the output disable time in cycles, with a minimum of 1.
- R4: In a write, chip select falls first and write enable falls SET_CYC cycles later. The memory address stays unchanged for as long as chip select is low.
- R5: Write enable stays low for exactly PULSE_CYC cycles. PULSE_CYC is the largest of three values: the write pulse width, the data setup time plus one, and the address-to-write-enable-rise setup time less SET_CYC. The data driver turns on in the second low cycle and turns off in the cycle in which write enable rises, so data is driven for PULSE_CYC-1 cycles before that edge.
- R6: Output enable is high throughout a write. Output enable and write enable are never low together, and the data driver is never on while output enable is low.
- R7: After write enable rises, the controller waits REC_CYC cycles (at least 1) with chip select high. This makes the whole write at least the write cycle time.
- R8: Ready is high for exactly one cycle. It comes in cycle RD_CYC+TURN_CYC after the request for a read, and in cycle SET_CYC+PULSE_CYC+REC_CYC for a write, counting the first cycle after the accepting edge as 1.
- R9: A request that arrives while an access is in progress is ignored. It changes neither the memory address, the memory contents nor the read data.
- R10: The cycle counts default to the ceiling of each limit divided by CLK_PS. With the fast grade at a 5 ns clock this gives RD_CYC=14, TURN_CYC=5, SET_CYC=1, PULSE_CYC=11 and REC_CYC=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled only while idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 19 | Word address |
| wdata_i | input | 8 | Write data |
| ready_o | output | 1 | One-cycle pulse at the end of each access |
| rdata_o | output | 8 | Byte from the most recent read |
| mem_addr_o | output | 19 | Memory address |
| mem_cs_no | output | 1 | Memory chip select, active low |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_dq_o | output | 8 | Data value driven toward the memory |
| mem_dq_oe_o | output | 1 | Data driver enable |
| mem_dq_i | input | 8 | Data value read from the memory |

## Verification
The hardest case to reach from the ports is a controller that samples read data a cycle early or cuts the write pulse short. A memory that answers instantly hides both faults. The bench therefore models the memory with timing. It returns a junk byte until the select and output-enable window has lasted the full access time. It also measures every write-enable low period and every driver-on period, cycle by cycle, against limits it computes itself. Requests raised in the middle of a write then show that the busy controller ignores them, by reading back the untouched location afterwards.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_TURN,
    ST_WR_SET,
    ST_WR_PULSE,
    ST_WR_REC
  } state_e;

  function automatic int ceil_cyc(input int ns, input int clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // access limits in ns per grade
  function automatic int t_addr_acc(input bit fast);   return fast ? 70 : 100; endfunction
  function automatic int t_cs_acc(input bit fast);     return fast ? 70 : 100; endfunction
  function automatic int t_oe_acc(input bit fast);     return fast ? 35 : 50;  endfunction
  function automatic int t_out_dis(input bit fast);    return fast ? 25 : 35;  endfunction
  function automatic int t_wr_pulse(input bit fast);   return fast ? 50 : 60;  endfunction
  function automatic int t_data_su(input bit fast);    return fast ? 30 : 35;  endfunction
  function automatic int t_addr_wh_su(input bit fast); return fast ? 60 : 80;  endfunction
  function automatic int t_wr_cycle(input bit fast);   return fast ? 70 : 100; endfunction

  function automatic int rd_cycles(input bit fast, input int clk_ps);
    return imax(imax(ceil_cyc(t_addr_acc(fast), clk_ps), ceil_cyc(t_cs_acc(fast), clk_ps)),
                imax(ceil_cyc(t_oe_acc(fast), clk_ps), 1));
  endfunction

  function automatic int turn_cycles(input bit fast, input int clk_ps);
    return imax(ceil_cyc(t_out_dis(fast), clk_ps), 1);
  endfunction

  // address setup to write-enable fall is 0 ns; keep one cycle
  function automatic int set_cycles(input bit fast, input int clk_ps);
    return imax(ceil_cyc(fast ? 0 : 0, clk_ps), 1);
  endfunction

  function automatic int pulse_cycles(input bit fast, input int clk_ps);
    return imax(imax(ceil_cyc(t_wr_pulse(fast), clk_ps), ceil_cyc(t_data_su(fast), clk_ps) + 1),
                imax(ceil_cyc(t_addr_wh_su(fast), clk_ps) - set_cycles(fast, clk_ps), 2));
  endfunction

  function automatic int rec_cycles(input bit fast, input int clk_ps);
    return imax(ceil_cyc(t_wr_cycle(fast), clk_ps) - set_cycles(fast, clk_ps)
                - pulse_cycles(fast, clk_ps), 1);
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int RD_CYC    = 14,
  parameter int TURN_CYC  = 5,
  parameter int SET_CYC   = 1,
  parameter int PULSE_CYC = 11,
  parameter int REC_CYC   = 2,
  parameter int CNT_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             ready_o,
  output logic             cs_no,
  output logic             we_no,
  output logic             oe_no,
  output logic             dq_oe_o
);

  localparam logic [CNT_W-1:0] RdLd    = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TurnLd  = CNT_W'(TURN_CYC - 1);
  localparam logic [CNT_W-1:0] SetLd   = CNT_W'(SET_CYC - 1);
  localparam logic [CNT_W-1:0] PulseLd = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] RecLd   = CNT_W'(REC_CYC - 1);

  state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    ready_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          accept_o   = 1'b1;
          load_o     = 1'b1;
          state_d    = we_i ? ST_WR_SET : ST_RD_ACC;
          load_val_o = we_i ? SetLd : RdLd;
        end
      end
      ST_RD_ACC: begin
        if (zero_i) begin
          capture_o  = 1'b1;
          load_o     = 1'b1;
          load_val_o = TurnLd;
          state_d    = ST_RD_TURN;
        end
      end
      ST_RD_TURN: begin
        if (zero_i) begin
          ready_o = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WR_SET: begin
        if (zero_i) begin
          load_o     = 1'b1;
          load_val_o = PulseLd;
          state_d    = ST_WR_PULSE;
        end
      end
      ST_WR_PULSE: begin
        if (zero_i) begin
          load_o     = 1'b1;
          load_val_o = RecLd;
          state_d    = ST_WR_REC;
        end
      end
      ST_WR_REC: begin
        if (zero_i) begin
          ready_o = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // strobes decode from registered state only
  assign cs_no   = !(state_q == ST_RD_ACC || state_q == ST_WR_SET || state_q == ST_WR_PULSE);
  assign oe_no   = (state_q != ST_RD_ACC);
  assign we_no   = (state_q != ST_WR_PULSE);
  // driver waits one cycle after write enable falls
  assign dq_oe_o = (state_q == ST_WR_PULSE) && (cnt_i != PulseLd);

endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [DATA_W-1:0] rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o <= '0;
      mem_dq_o   <= '0;
    end else if (accept_i) begin
      mem_addr_o <= addr_i;
      mem_dq_o   <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= '0;
    else if (capture_i) rdata_o <= mem_dq_i;
  end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 8,
  parameter int CLK_PS     = 5000,
  parameter bit FAST_GRADE = 1'b1,
  parameter int RD_CYC     = rd_cycles(FAST_GRADE, CLK_PS),
  parameter int TURN_CYC   = turn_cycles(FAST_GRADE, CLK_PS),
  parameter int SET_CYC    = set_cycles(FAST_GRADE, CLK_PS),
  parameter int PULSE_CYC  = pulse_cycles(FAST_GRADE, CLK_PS),
  parameter int REC_CYC    = rec_cycles(FAST_GRADE, CLK_PS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int MaxCyc = imax(imax(imax(RD_CYC, TURN_CYC), imax(SET_CYC, PULSE_CYC)), REC_CYC);
  localparam int CntW   = imax($clog2(MaxCyc + 1), 1);

  logic            load;
  logic [CntW-1:0] load_val;
  logic [CntW-1:0] cnt;
  logic            zero;
  logic            accept;
  logic            capture;

  sram_ctl_timer #(.CNT_W(CntW)) timer_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .cnt_o      (cnt),
    .zero_o     (zero)
  );

  sram_ctl_fsm #(
    .RD_CYC    (RD_CYC),
    .TURN_CYC  (TURN_CYC),
    .SET_CYC   (SET_CYC),
    .PULSE_CYC (PULSE_CYC),
    .REC_CYC   (REC_CYC),
    .CNT_W     (CntW)
  ) fsm_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .cnt_i      (cnt),
    .zero_i     (zero),
    .load_o     (load),
    .load_val_o (load_val),
    .accept_o   (accept),
    .capture_o  (capture),
    .ready_o    (ready_o),
    .cs_no      (mem_cs_no),
    .we_no      (mem_we_no),
    .oe_no      (mem_oe_no),
    .dq_oe_o    (mem_dq_oe_o)
  );

  sram_ctl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .capture_i  (capture),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .mem_dq_i   (mem_dq_i),
    .mem_addr_o (mem_addr_o),
    .mem_dq_o   (mem_dq_o),
    .rdata_o    (rdata_o)
  );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int ADDR_W    = 19,
  parameter int RD_CYC    = 14,
  parameter int PULSE_CYC = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_cs_no,
  input logic              mem_we_no,
  input logic              mem_oe_no,
  input logic              mem_dq_oe_o
);

  int wl_cnt;
  int rd_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wl_cnt <= 0;
      rd_cnt <= 0;
    end else begin
      wl_cnt <= !mem_we_no ? wl_cnt + 1 : 0;
      rd_cnt <= (!mem_oe_no && !mem_cs_no) ? rd_cnt + 1 : 0;
    end
  end

  // R1
  deselect_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_cs_no |-> (mem_we_no && mem_oe_no && !mem_dq_oe_o));

  // R6
  oe_we_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no));

  // R6
  drive_needs_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (!mem_we_no && mem_oe_no));

  // R5
  we_rise_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> !mem_dq_oe_o);

  // R5
  drive_after_we_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_no) |-> !mem_dq_oe_o);

  // R5
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (wl_cnt >= PULSE_CYC));

  // R2
  read_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_oe_no) |-> (rd_cnt >= RD_CYC));

  // R4
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_no && $past(!mem_cs_no)) |-> $stable(mem_addr_o));

  // R8
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  // R8
  ready_deselected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> mem_cs_no);

endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W    (ADDR_W),
  .RD_CYC    (RD_CYC),
  .PULSE_CYC (PULSE_CYC)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ready_o     (ready_o),
  .mem_addr_o  (mem_addr_o),
  .mem_cs_no   (mem_cs_no),
  .mem_we_no   (mem_we_no),
  .mem_oe_no   (mem_oe_no),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/sram_ctl_tb_top.sv
`timescale 1ns/1ps
module sram_ctl_tb_top;

  localparam int CLK_NS = 5;

  function automatic int cdiv(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // fast grade limits, expected cycle counts (R10)
  localparam int RD_E    = mx(cdiv(70), cdiv(35));
  localparam int TURN_E  = mx(cdiv(25), 1);
  localparam int SET_E   = 1;
  localparam int PULSE_E = mx(mx(cdiv(50), cdiv(30) + 1), cdiv(60) - SET_E);
  localparam int REC_E   = mx(cdiv(70) - SET_E - PULSE_E, 1);
  localparam int RD_LAT  = RD_E + TURN_E;
  localparam int WR_LAT  = SET_E + PULSE_E + REC_E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready;
  logic [7:0]  rdata;
  logic [18:0] mem_addr;
  logic        cs_n, we_n, oe_n;
  logic [7:0]  dq_o;
  logic        dq_oe;
  logic [7:0]  dq_i = 8'hEE;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  sram_ctl dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_i       (req),
    .we_i        (we),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .ready_o     (ready),
    .rdata_o     (rdata),
    .mem_addr_o  (mem_addr),
    .mem_cs_no   (cs_n),
    .mem_we_no   (we_n),
    .mem_oe_no   (oe_n),
    .mem_dq_o    (dq_o),
    .mem_dq_oe_o (dq_oe),
    .mem_dq_i    (dq_i)
  );

  // timed memory model, evaluated mid-cycle
  logic [7:0] mem [int];
  int  rd_run = 0, last_rd = 0;
  int  wl_run = 0, dd_run = 0, last_wl = 0, last_dd = 0;
  int  n_writes = 0;
  int  viol_bus = 0, viol_addr = 0;
  logic [7:0]  wlat = '0;
  logic        prev_we_low = 1'b0, prev_cs_low = 1'b0, prev_rd = 1'b0;
  logic [18:0] prev_addr = '0;

  function automatic logic [7:0] mem_rd(input logic [18:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 8'h5A;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (dq_oe && (!oe_n || we_n)) viol_bus++;
      if (!oe_n && !we_n) viol_bus++;
      if (!cs_n && prev_cs_low && mem_addr != prev_addr) viol_addr++;
      if (!cs_n && !oe_n && we_n) rd_run++;
      else begin
        if (prev_rd) last_rd = rd_run;
        rd_run = 0;
      end
      if (!we_n) begin
        wl_run++;
        if (dq_oe) begin dd_run++; wlat = dq_o; end
      end else if (prev_we_low) begin
        last_wl = wl_run;
        last_dd = dd_run;
        if (dd_run > 0) mem[int'(mem_addr)] = wlat;
        n_writes++;
        wl_run = 0;
        dd_run = 0;
      end
      dq_i = (rd_run >= RD_E) ? mem_rd(mem_addr) : 8'hEE;
      prev_rd     = !cs_n && !oe_n && we_n;
      prev_we_low = !we_n;
      prev_cs_low = !cs_n;
      prev_addr   = mem_addr;
    end
  end

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic issue(input logic w, input logic [18:0] a, input logic [7:0] d, output int lat);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    lat = 1;
    while (!ready && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset();
    chk("R1 idle strobes cs/we/oe/drv/ready", {cs_n, we_n, oe_n, dq_oe, ready}, 5'b11100);
    chk("R1 rdata reset", rdata, 0);
  endtask

  task automatic t_write(input logic [18:0] a, input logic [7:0] d);
    int lat, w0;
    w0 = n_writes;
    issue(1'b1, a, d, lat);
    chk("R8 R7 write latency", lat, WR_LAT);
    @(negedge clk);
    chk("R8 ready one cycle (write)", ready, 0);
    chk("R1 deselected after write", cs_n, 1);
    chk("R5 R10 write pulse cycles", last_wl, PULSE_E);
    chk("R5 data driven cycles", last_dd, PULSE_E - 1);
    chk("R4 one write per access", n_writes - w0, 1);
    chk("R5 stored byte", mem_rd(a), d);
  endtask

  task automatic t_read(input logic [18:0] a, input logic [7:0] exp);
    int lat;
    issue(1'b0, a, 8'h00, lat);
    chk("R3 R8 read latency", lat, RD_LAT);
    chk("R2 read data", rdata, exp);
    @(negedge clk);
    chk("R8 ready one cycle (read)", ready, 0);
    chk("R2 R10 read window cycles", last_rd, RD_E);
    chk("R2 rdata held", rdata, exp);
  endtask

  task automatic t_busy_ignore();
    int lat, w0;
    w0 = n_writes;
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 19'h00777; wdata = 8'hC3;
    @(negedge clk);
    req = 1'b0;
    lat = 1;
    repeat (2) begin @(negedge clk); lat++; end
    // intruding write while busy
    req = 1'b1; we = 1'b1; addr = 19'h00123; wdata = 8'h99;
    @(negedge clk); lat++;
    req = 1'b0;
    repeat (3) begin @(negedge clk); lat++; end
    // intruding read while busy
    req = 1'b1; we = 1'b0; addr = 19'h7FFFF;
    @(negedge clk); lat++;
    req = 1'b0;
    while (!ready && lat < 200) begin @(negedge clk); lat++; end
    chk("R9 latency unchanged by intruders", lat, WR_LAT);
    @(negedge clk);
    chk("R9 single write performed", n_writes - w0, 1);
    chk("R9 write target intact", mem_rd(19'h00777), 8'hC3);
    chk("R9 intruder address untouched", mem_rd(19'h00123), 8'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    chk("R10 expected counts", RD_E * 10000 + TURN_E * 1000 + PULSE_E * 10 + REC_E, 145112);
    t_write(19'h00123, 8'h11);
    t_read(19'h00123, 8'h11);
    t_write(19'h7FFFF, 8'hA5);
    t_write(19'h00000, 8'h3C);
    t_read(19'h7FFFF, 8'hA5);
    t_read(19'h00000, 8'h3C);
    t_read(19'h40000, 8'h5A);
    t_write(19'h40000, 8'hFF);
    t_read(19'h40000, 8'hFF);
    t_busy_ignore();
    t_read(19'h00777, 8'hC3);
    t_read(19'h00123, 8'h11);
    chk("R6 bus contention events", viol_bus, 0);
    chk("R4 address changes while selected", viol_addr, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule